// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier with Carry-Select Summation

This block multiplies two signed two's complement operands of equal width N and returns their full-width signed product of 2N bits. It is purely combinational and is meant for the multiply stage of a filter tap, where a coefficient and a sample meet. It has no clock and no reset. The product follows the operands within the same cycle.

Internally, the multiplier operand gets a zero bit appended below its LSB. It is then cut into overlapping bit triplets, and each triplet becomes one signed digit in the range -2 to +2. When N is odd, the sign bit is repeated once so that the top triplet is complete. Each digit selects one of 0, +M, -M, +2M or -2M, where M is the multiplicand sign-extended to 2N bits. The value -M comes from a ripple-carry negation unit that inverts M and adds one. Each selected term is placed two bit positions above the previous one. There are ceil(N/2) such terms. They are accumulated by a chain of carry-select adders split into 4-bit sections.

Top module: `bmul_top`

## Requirements
- R1: For every pair of N-bit signed operands, `product_o` equals the exact signed product, read as a 2N-bit two's complement value (default N = 16).
- R2: The most negative operand times itself gives +2^(2N-2) without wrap-around, and the most negative value times the most positive value is also exact.
- R3: For odd N, the product is exact for all operand pairs; the sign bit of the multiplier is replicated once to complete the last triplet.
- R4: Each triplet {upper, middle, lower} maps to a digit as follows: 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, and 101 and 110 give -1. The digit therefore equals -2*upper + middle + lower. The lowest triplet uses the appended zero as its lower bit.
- R5: The negated multiplicand equals -M modulo 2^(2N). A multiplier of -1 therefore yields -M, and this includes M at its most negative value.
- R6: Multiplier values of +2 and -2 yield 2M and -2M with the correct sign, for the extreme multiplicand values.
- R7: Each carry-select adder returns (a + b) mod 2^W, including cases where a carry ripples through every 4-bit section.
- R8: The block holds no state: the product depends only on the present operands, and a zero operand gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_i | input | N | Signed multiplicand (two's complement) |
| mplier_i | input | N | Signed multiplier operand, Booth-recoded |
| product_o | output | 2N | Signed product (two's complement) |

## Verification
The product is combinational, so each result is due in the same cycle in which its operands change, with no register on the path. The bench drives a new operand pair just after a rising clock edge. It samples the product at the following falling edge, half a period later. It never carries an expectation across an edge. Small odd and even instances are swept over every operand pair. The 16-bit instance is checked over corner operands and random pairs, against products computed arithmetically in the bench.

// File: rtl/bmul_pkg.sv
package bmul_pkg;

    localparam int SECT_W = 4;

    typedef enum logic [2:0] {
        DIG_ZERO = 3'd0,
        DIG_P1   = 3'd1,
        DIG_P2   = 3'd2,
        DIG_M1   = 3'd3,
        DIG_M2   = 3'd4
    } digit_e;

    function automatic digit_e decode_triplet(input logic [2:0] t);
        digit_e d;
        case (t)
            3'b001, 3'b010: d = DIG_P1;
            3'b011:         d = DIG_P2;
            3'b100:         d = DIG_M2;
            3'b101, 3'b110: d = DIG_M1;
            default:        d = DIG_ZERO;
        endcase
        return d;
    endfunction

    function automatic int digit_value(input digit_e d);
        int v;
        case (d)
            DIG_P1:  v = 1;
            DIG_P2:  v = 2;
            DIG_M1:  v = -1;
            DIG_M2:  v = -2;
            default: v = 0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/bmul_negate.sv
module bmul_negate #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] neg_o
);
    logic [W:0] carry;
    assign carry[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_rip
        assign neg_o[i]     = ~val_i[i] ^ carry[i];
        assign carry[i+1]   = ~val_i[i] & carry[i];
    end

    logic [W-1:0] total;
    always_comb begin
        total = neg_o + val_i;
        // R5
        neg_value_chk: assert (total == '0)
            else $error("negation unit output is not the additive inverse");
    end
endmodule

// File: rtl/bmul_recoder.sv
module bmul_recoder #(
    parameter int N   = 16,
    parameter int NPP = (N + 1) / 2
) (
    input  logic [N-1:0]     mplier_i,
    output bmul_pkg::digit_e dig_o [NPP]
);
    localparam int YW = 2 * NPP;

    logic [YW:0] yz;

    if (YW > N) begin : g_odd
        assign yz = {mplier_i[N-1], mplier_i, 1'b0};
    end else begin : g_even
        assign yz = {mplier_i, 1'b0};
    end

    for (genvar i = 0; i < NPP; i++) begin : g_dig
        always_comb begin
            dig_o[i] = bmul_pkg::decode_triplet(yz[2*i+2 -: 3]);
        end
        always_comb begin
            // R4
            digit_range_chk: assert (bmul_pkg::digit_value(dig_o[i]) ==
                -2 * int'(yz[2*i+2]) + int'(yz[2*i+1]) + int'(yz[2*i]))
                else $error("Booth digit does not match its triplet");
        end
    end
endmodule

// File: rtl/bmul_ppgen.sv
module bmul_ppgen #(
    parameter int PW    = 32,
    parameter int SHIFT = 0
) (
    input  logic [PW-1:0]    m_ext_i,
    input  logic [PW-1:0]    m_neg_i,
    input  bmul_pkg::digit_e dig_i,
    output logic [PW-1:0]    pp_o
);
    logic [PW-1:0] pick;

    always_comb begin
        case (dig_i)
            bmul_pkg::DIG_P1: pick = m_ext_i;
            bmul_pkg::DIG_P2: pick = m_ext_i << 1;
            bmul_pkg::DIG_M1: pick = m_neg_i;
            bmul_pkg::DIG_M2: pick = m_neg_i << 1;
            default:          pick = '0;
        endcase
        pp_o = pick << SHIFT;
    end
endmodule

// File: rtl/bmul_csel_add.sv
module bmul_csel_add #(
    parameter int W  = 32,
    parameter int SW = bmul_pkg::SECT_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    localparam int NS = (W + SW - 1) / SW;

    logic [NS-1:0] c;
    assign c[0] = 1'b0;

    for (genvar s = 0; s < NS; s++) begin : g_sec
        localparam int LO  = s * SW;
        localparam int SWD = (W - LO < SW) ? (W - LO) : SW;
        if (s == NS - 1) begin : g_last
            logic [SWD-1:0] r0, r1;
            assign r0 = a_i[LO +: SWD] + b_i[LO +: SWD];
            assign r1 = a_i[LO +: SWD] + b_i[LO +: SWD] + SWD'(1);
            assign sum_o[LO +: SWD] = c[s] ? r1 : r0;
        end else begin : g_mid
            logic [SWD:0] r0, r1;
            assign r0 = {1'b0, a_i[LO +: SWD]} + {1'b0, b_i[LO +: SWD]};
            assign r1 = {1'b0, a_i[LO +: SWD]} + {1'b0, b_i[LO +: SWD]} + (SWD+1)'(1);
            assign sum_o[LO +: SWD] = c[s] ? r1[SWD-1:0] : r0[SWD-1:0];
            assign c[s+1]           = c[s] ? r1[SWD] : r0[SWD];
        end
    end

    logic [W-1:0] direct;
    always_comb begin
        direct = a_i + b_i;
        // R7
        csa_sum_chk: assert (sum_o == direct)
            else $error("carry-select sum mismatch");
    end
endmodule

// File: rtl/bmul_top.sv
module bmul_top #(
    parameter int N = 16
) (
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic [2*N-1:0] product_o
);
    localparam int NPP = (N + 1) / 2;
    localparam int PW  = 2 * N;

    logic [PW-1:0]    m_ext, m_neg;
    bmul_pkg::digit_e dig [NPP];
    logic [PW-1:0]    pp  [NPP];
    logic [PW-1:0]    acc [NPP];

    assign m_ext = {{N{mcand_i[N-1]}}, mcand_i};

    bmul_negate #(.W(PW)) u_neg (
        .val_i (m_ext),
        .neg_o (m_neg)
    );

    bmul_recoder #(.N(N), .NPP(NPP)) u_rec (
        .mplier_i (mplier_i),
        .dig_o    (dig)
    );

    for (genvar i = 0; i < NPP; i++) begin : g_pp
        bmul_ppgen #(.PW(PW), .SHIFT(2*i)) u_pp (
            .m_ext_i (m_ext),
            .m_neg_i (m_neg),
            .dig_i   (dig[i]),
            .pp_o    (pp[i])
        );
    end

    assign acc[0] = pp[0];
    for (genvar i = 1; i < NPP; i++) begin : g_sum
        bmul_csel_add #(.W(PW)) u_add (
            .a_i   (acc[i-1]),
            .b_i   (pp[i]),
            .sum_o (acc[i])
        );
    end

    assign product_o = acc[NPP-1];

    logic signed [PW-1:0] golden;
    always_comb begin
        golden = $signed(m_ext) * $signed({{N{mplier_i[N-1]}}, mplier_i});
        // R1
        product_chk: assert ($signed(product_o) == golden)
            else $error("product differs from signed multiply");
    end
endmodule

// File: tb/bmul_top_test.sv
module bmul_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] a16 = '0, b16 = '0;
    logic [31:0] p16;
    logic [4:0]  a5 = '0, b5 = '0;
    logic [9:0]  p5;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  p4;

    bmul_top #(.N(16)) uut   (.mcand_i(a16), .mplier_i(b16), .product_o(p16));
    bmul_top #(.N(5))  u_odd (.mcand_i(a5),  .mplier_i(b5),  .product_o(p5));
    bmul_top #(.N(4))  u_evn (.mcand_i(a4),  .mplier_i(b4),  .product_o(p4));

    task automatic check(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic run16(input string tag, input logic [15:0] a, input logic [15:0] b);
        @(posedge clk); #1;
        a16 = a; b16 = b;
        @(negedge clk);
        check(tag, longint'($signed(p16)),
              longint'($signed(a)) * longint'($signed(b)));
    endtask

    initial begin
        logic [15:0] corners [7];
        corners = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001, 16'h0002, 16'hFFFE};

        repeat (3) @(posedge clk);
        // R8: zero operands give a zero product while reset is held
        @(negedge clk);
        check("R8 zero during reset", longint'($signed(p16)), 0);
        check("R8 zero narrow", longint'($signed(p5)) + longint'($signed(p4)), 0);
        rst = 1'b0;

        // R2: extreme corner products
        run16("R2 min*min", 16'h8000, 16'h8000);
        check("R2 min*min value", longint'($signed(p16)), longint'(1) <<< 30);
        run16("R2 min*max", 16'h8000, 16'h7FFF);
        run16("R2 max*min", 16'h7FFF, 16'h8000);

        // R1: all corner pairs
        foreach (corners[i]) foreach (corners[j])
            run16("R1 corner", corners[i], corners[j]);

        // R5: multiplier -1 yields -M
        run16("R5 min*-1", 16'h8000, 16'hFFFF);
        for (int k = 0; k < 40; k++) run16("R5 x*-1", 16'($urandom), 16'hFFFF);

        // R6: multiplier +/-2 selects 2M / -2M
        run16("R6 min*2",  16'h8000, 16'h0002);
        run16("R6 min*-2", 16'h8000, 16'hFFFE);
        run16("R6 max*2",  16'h7FFF, 16'h0002);
        run16("R6 max*-2", 16'h7FFF, 16'hFFFE);

        // R7: carry ripples through every adder section
        run16("R7 1*-1",  16'h0001, 16'hFFFF);
        run16("R7 -1*1",  16'hFFFF, 16'h0001);
        run16("R7 -1*-1", 16'hFFFF, 16'hFFFF);
        run16("R7 5555",  16'h5555, 16'hAAAB);

        // R1: random pairs
        for (int k = 0; k < 1500; k++) run16("R1 random", 16'($urandom), 16'($urandom));

        // R3: odd width, every pair
        for (int x = 0; x < 32; x++) begin
            for (int y = 0; y < 32; y++) begin
                @(posedge clk); #1;
                a5 = 5'(x); b5 = 5'(y);
                @(negedge clk);
                check("R3 odd width", longint'($signed(p5)),
                      longint'($signed(5'(x))) * longint'($signed(5'(y))));
            end
        end

        // R4: even width, every pair (covers every triplet pattern)
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                @(posedge clk); #1;
                a4 = 4'(x); b4 = 4'(y);
                @(negedge clk);
                check("R4 triplet sweep", longint'($signed(p4)),
                      longint'($signed(4'(x))) * longint'($signed(4'(y))));
            end
        end

        // R8: same operands give the same product regardless of history
        run16("R8 repeat a", 16'h1234, 16'hFEDC);
        run16("R8 repeat b", 16'h1234, 16'hFEDC);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule